// File: doc/BRIEF.md
# Single-Wire Parity Byte Framer

This block moves one data chunk at a time over a single bidirectional wire. A chunk holds either the full data width or one bit less. The block can act as sender or receiver, one chunk per request. As sender it marks the start of a chunk with a low pulse one bit period long, followed by a one-cycle high marker. It then shifts the chunk out most significant bit first, adds an even-parity bit, and leaves the wire driven low. The low level guarantees that the next start pulse ends in a clean rising edge.

As receiver it first releases the wire and passes the sampled line through a synchronizer. It then hunts for the low pulse for a bounded time and locks onto the rising edge that ends the pulse. Each data bit and the parity bit are sampled half a bit period into their slot. The receiver returns the chunk with a one-cycle valid strobe and a flag that is set when the parity does not match. Sequencing of chunks into transactions and any handshaking between the two ends belong to the logic around the block.

The bit period is a parameter in clock cycles. At 250 MHz, 1500 cycles gives the 6 microsecond period used by default. Periods of 4, 12, 24, 36 and 48 microseconds are reached by scaling the parameter.

Top module: `swf_framer`

## Requirements
- R1: After reset the wire is released (line_oe=0), line_out is 1, ready is 1 and rx_valid is 0.
- R2: A send request is accepted on a clock edge where req_valid, req_send and ready are all 1. The line is then driven low for BIT_CYCLES cycles, starting the cycle after that edge, and then driven high for exactly one cycle.
- R3: The data bits follow the high cycle, most significant first, each held for BIT_CYCLES cycles. With req_len_full=1 all 8 bits of req_data go out (bit 7 first). With req_len_full=0 only req_data[6:0] goes out (bit 6 first).
- R4: After the data bits, one parity bit is held for BIT_CYCLES cycles. It equals the XOR of the data bits sent, so the parity is even.
- R5: When the parity bit ends, the line stays driven (line_oe=1) at 0. ready returns to 1 exactly (n+2)*BIT_CYCLES+1 cycles after the accepting edge, where n is the chunk length.
- R6: A receive request is accepted on an edge with req_valid=1, req_send=0 and ready=1. From the next cycle the wire is released (line_oe=0).
- R7: The receiver samples each bit half a period into its slot and shifts the bits in most significant first. A 7-bit chunk is returned in rx_data[6:0] with rx_data[7]=0.
- R8: rx_perr is 1 exactly when the received parity bit differs from the XOR of the received data bits.
- R9: rx_valid is a one-cycle pulse. It is due (SYNC_STAGES+1)+BIT_CYCLES/2+1+n*BIT_CYCLES cycles after the line rises at the end of the start pulse.
- R10: If the synchronized line has not gone low within HUNT_PERIODS*BIT_CYCLES cycles of the receive accept, the end of that window is taken as the start of the data. A line held high then yields all ones, so rx_perr=1 for an 8-bit chunk and rx_perr=0 for a 7-bit chunk.
- R11: Requests presented while ready is 0 are ignored. The frame in progress continues unchanged, and the line is not released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request for one chunk |
| req_send | input | 1 | 1 = send req_data, 0 = receive a chunk |
| req_len_full | input | 1 | 1 = DATA_W bits, 0 = DATA_W-1 bits |
| req_data | input | DATA_W | Chunk to send |
| ready | output | 1 | No chunk in progress; a request is accepted |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Value driven onto the wire |
| line_in | input | 1 | Sampled wire level |
| rx_valid | output | 1 | One-cycle strobe for a received chunk |
| rx_data | output | DATA_W | Received chunk, right-aligned |
| rx_perr | output | 1 | Parity mismatch on the received chunk |

## Verification
On the sending side, every line level has a fixed cycle relative to the accepting edge, called a. The start pulse is low from a+1 to a+P. The marker is high after a+P. Bit k begins after a+P+1+k*P. The bench samples each level at the middle of its slot and checks ready one cycle before and on the cycle a+(n+2)P+1.

On the receiving side, the bench drives the wire itself and counts the two synchronizer stages and the receiver register. From that it predicts the exact cycle of the rx_valid pulse and checks that rx_valid is low one cycle before and high on that cycle. The timeout case uses the hunt window, counted from the accept edge, in place of the edge that the bench drives in the other cases.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SYNC,
    TX_MARK,
    TX_BITS
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_HUNT,
    RX_LOW,
    RX_BITS
  } rx_state_t;
endpackage

// File: rtl/swf_line_sync.sv
module swf_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/swf_tx.sv
module swf_tx
  import swf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 1500,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              len_full,
  input  logic [DATA_W-1:0] data,
  input  logic              release_line,
  output logic              busy,
  output logic              oe,
  output logic              dout
);
  localparam int BL_W = $clog2(DATA_W + 1);

  tx_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [BL_W-1:0]   left;
  logic              par;
  logic              in_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      oe     <= 1'b0;
      dout   <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
      left   <= '0;
      par    <= 1'b0;
      in_par <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (start) begin
            st     <= TX_SYNC;
            oe     <= 1'b1;
            dout   <= 1'b0;
            cnt    <= CNT_W'(BIT_CYCLES - 1);
            shreg  <= len_full ? data : {data[DATA_W-2:0], 1'b0};
            left   <= len_full ? BL_W'(DATA_W) : BL_W'(DATA_W - 1);
            par    <= 1'b0;
            in_par <= 1'b0;
          end else if (release_line) begin
            oe   <= 1'b0;
            dout <= 1'b1;
          end
        end
        TX_SYNC: begin
          if (cnt == '0) begin
            st   <= TX_MARK;
            dout <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        TX_MARK: begin
          st    <= TX_BITS;
          dout  <= shreg[DATA_W-1];
          par   <= par ^ shreg[DATA_W-1];
          shreg <= {shreg[DATA_W-2:0], 1'b0};
          left  <= left - 1'b1;
          cnt   <= CNT_W'(BIT_CYCLES - 1);
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (left != '0) begin
            dout  <= shreg[DATA_W-1];
            par   <= par ^ shreg[DATA_W-1];
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            left  <= left - 1'b1;
            cnt   <= CNT_W'(BIT_CYCLES - 1);
          end else if (!in_par) begin
            dout   <= par;
            in_par <= 1'b1;
            cnt    <= CNT_W'(BIT_CYCLES - 1);
          end else begin
            dout <= 1'b0;
            st   <= TX_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (st != TX_IDLE);
endmodule

// File: rtl/swf_rx.sv
module swf_rx
  import swf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BIT_CYCLES  = 1500,
  parameter int HUNT_CYCLES = 7500,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              len_full,
  input  logic              din,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              perr
);
  localparam int BL_W = $clog2(DATA_W + 1);
  localparam int HALF = BIT_CYCLES / 2;

  rx_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [BL_W-1:0]   left;
  logic              par;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      shreg <= '0;
      left  <= '0;
      par   <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (start) begin
            st    <= RX_HUNT;
            cnt   <= CNT_W'(HUNT_CYCLES - 1);
            shreg <= '0;
            left  <= len_full ? BL_W'(DATA_W) : BL_W'(DATA_W - 1);
            par   <= 1'b0;
          end
        end
        RX_HUNT: begin
          if (!din) begin
            st <= RX_LOW;
          end else if (cnt == '0) begin
            st  <= RX_BITS;
            cnt <= CNT_W'(HALF);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_LOW: begin
          if (din) begin
            st  <= RX_BITS;
            cnt <= CNT_W'(HALF);
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= CNT_W'(BIT_CYCLES - 1);
            if (left != '0) begin
              shreg <= {shreg[DATA_W-2:0], din};
              par   <= par ^ din;
              left  <= left - 1'b1;
            end else begin
              valid <= 1'b1;
              data  <= shreg;
              perr  <= par ^ din;
              st    <= RX_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign busy = (st != RX_IDLE);
endmodule

// File: rtl/swf_framer.sv
module swf_framer #(
  parameter int DATA_W       = 8,
  parameter int BIT_CYCLES   = 1500,
  parameter int SYNC_STAGES  = 2,
  parameter int HUNT_PERIODS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_send,
  input  logic              req_len_full,
  input  logic [DATA_W-1:0] req_data,
  output logic              ready,
  output logic              line_oe,
  output logic              line_out,
  input  logic              line_in,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr
);
  localparam int HUNT_CYCLES = BIT_CYCLES * HUNT_PERIODS;
  localparam int CNT_W       = $clog2(HUNT_CYCLES + 1);

  logic tx_busy, rx_busy, line_sync;
  logic accept, tx_start, rx_start;

  assign ready    = !tx_busy && !rx_busy;
  assign accept   = req_valid && ready;
  assign tx_start = accept && req_send;
  assign rx_start = accept && !req_send;

  swf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (line_in),
    .dout(line_sync)
  );

  swf_tx #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES), .CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .start       (tx_start),
    .len_full    (req_len_full),
    .data        (req_data),
    .release_line(rx_start),
    .busy        (tx_busy),
    .oe          (line_oe),
    .dout        (line_out)
  );

  swf_rx #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES),
           .HUNT_CYCLES(HUNT_CYCLES), .CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .start   (rx_start),
    .len_full(req_len_full),
    .din     (line_sync),
    .busy    (rx_busy),
    .valid   (rx_valid),
    .data    (rx_data),
    .perr    (rx_perr)
  );
endmodule

// File: rtl/swf_framer_chk.sv
module swf_framer_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_send,
  input logic ready,
  input logic line_oe,
  input logic line_out,
  input logic rx_valid
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ready && !line_oe && line_out && !rx_valid));

  p_sync_low_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_send && ready) |=> (line_oe && !line_out && !ready));

  p_hold_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (line_oe && !ready) |=> line_oe);

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_send && ready) |=> !line_oe);

  p_rx_while_released_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !line_oe);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_ready_at_result_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ready);
endmodule

bind swf_framer swf_framer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_send (req_send),
  .ready    (ready),
  .line_oe  (line_oe),
  .line_out (line_out),
  .rx_valid (rx_valid)
);

// File: tb/swf_framer_bench.sv
module swf_framer_bench;
  localparam int P  = 8;
  localparam int HP = 5;
  localparam int H  = P * HP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_send = 1'b0;
  logic       req_len_full = 1'b1;
  logic [7:0] req_data = 8'h00;
  logic       ready, line_oe, line_out, rx_valid, rx_perr;
  logic       line_drv = 1'b1;
  logic [7:0] rx_data;
  int         cyc = 0;
  int         checks = 0;
  int         failures = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swf_framer #(.DATA_W(8), .BIT_CYCLES(P), .SYNC_STAGES(2), .HUNT_PERIODS(HP)) u_swf_framer (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_send    (req_send),
    .req_len_full(req_len_full),
    .req_data    (req_data),
    .ready       (ready),
    .line_oe     (line_oe),
    .line_out    (line_out),
    .line_in     (line_drv),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_perr     (rx_perr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    do @(negedge clk); while (cyc < t);
  endtask

  task automatic do_send(input logic [7:0] d, input bit full, input bit interfere);
    int n, a;
    logic [8:0] got, exp;
    n = full ? 8 : 7;
    exp = '0;
    for (int k = 0; k < n; k++) exp[k] = d[n-1-k];
    exp[n] = ^exp;
    got = '0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_send = 1'b1; req_len_full = full; req_data = d;
    @(negedge clk);
    a = cyc;
    req_valid = 1'b0;
    wait_cyc(a + P/2);
    chk(line_oe && !line_out, "R2 sync low", {line_oe, line_out}, 2);
    wait_cyc(a + P);
    chk(line_oe && line_out, "R2 marker high", {line_oe, line_out}, 3);
    for (int k = 0; k <= n; k++) begin
      wait_cyc(a + P + 1 + k*P + P/2);
      got[k] = line_out;
      if (interfere && k == 1) begin
        req_valid = 1'b1; req_send = 1'b0; req_data = ~d;
      end
      if (interfere && k == 2) req_valid = 1'b0;
    end
    if (interfere)
      chk(got == exp && line_oe, "R11 busy request ignored", got, exp);
    chk(got[7:0] == exp[7:0], "R3 data bits msb first", got[7:0], exp[7:0]);
    chk(got[n] == exp[n], "R4 even parity bit", got[n], exp[n]);
    wait_cyc(a + (n+2)*P);
    chk(!ready, "R5 busy until parity end", ready, 0);
    wait_cyc(a + (n+2)*P + 1);
    chk(ready && line_oe && !line_out, "R5 ready with line held low",
        {ready, line_oe, line_out}, 6);
  endtask

  // mode 0: normal, 1: wrong parity, 2: line never goes low
  task automatic do_recv(input logic [7:0] d, input bit full, input int mode);
    int n, a, c, v;
    logic p;
    logic [7:0] ed;
    logic ep;
    n = full ? 8 : 7;
    c = 0;
    p = 1'b0;
    for (int k = 0; k < n; k++) p = p ^ d[n-1-k];
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_send = 1'b0; req_len_full = full; req_data = 8'h00;
    @(negedge clk);
    a = cyc;
    req_valid = 1'b0;
    chk(!line_oe, "R6 line released", line_oe, 0);
    if (mode != 2) begin
      c = a + 2;
      wait_cyc(c);
      line_drv = 1'b0;
      wait_cyc(c + P);
      line_drv = 1'b1;
      for (int k = 0; k < n; k++) begin
        wait_cyc(c + P + 1 + k*P);
        line_drv = d[n-1-k];
      end
      wait_cyc(c + P + 1 + n*P);
      line_drv = p ^ (mode == 1);
      v = c + P + P/2 + 4 + n*P;
      ed = full ? d : {1'b0, d[6:0]};
      ep = (mode == 1);
    end else begin
      v = a + H + P/2 + 1 + n*P;
      ed = full ? 8'hFF : 8'h7F;
      ep = full;
    end
    wait_cyc(v - 1);
    chk(!rx_valid, "R9 no early valid", rx_valid, 0);
    wait_cyc(v);
    chk(rx_valid, "R9 valid on due cycle", rx_valid, 1);
    if (mode == 2) begin
      chk(rx_data == ed, "R10 timeout data", rx_data, ed);
      chk(rx_perr == ep, "R10 timeout parity", rx_perr, ep);
    end else begin
      chk(rx_data == ed, "R7 received data", rx_data, ed);
      chk(rx_perr == ep, "R8 parity flag", rx_perr, ep);
    end
    wait_cyc(v + 1);
    chk(!rx_valid, "R9 single-cycle valid", rx_valid, 0);
    if (mode != 2) begin
      wait_cyc(c + 2*P + 1 + n*P);
      line_drv = 1'b1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!line_oe && line_out && ready && !rx_valid, "R1 reset state",
        {line_oe, line_out, ready, rx_valid}, 6);
    do_recv(8'h00, 1'b1, 2);
    do_recv(8'h00, 1'b0, 2);
    do_send(8'hA5, 1'b1, 1'b1);
    for (int i = 0; i < 256; i++) begin
      do_send(8'(i), 1'b1, 1'b0);
      do_recv(8'(i), 1'b1, (i % 8 == 3) ? 1 : 0);
    end
    for (int i = 0; i < 128; i++) begin
      do_send(8'(i) | 8'h80, 1'b0, 1'b0);
      do_recv(8'(i), 1'b0, (i % 8 == 5) ? 1 : 0);
    end
    do_recv(8'h00, 1'b1, 2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule